// File: doc/BRIEF.md
# USB Full-Speed Receive Elastic Buffer

This block decouples a recovered USB full-speed bit stream from the local bit-slot timing. The data-recovery stage presents one decoded line bit at a time with a valid strobe. The block stores these bits in a 16-entry circular store. Reading is held back until a prefill level has been reached. After that, the block hands out one stored bit for every local read slot. Because the producer and the consumer may run at slightly different rates, the prefill margin absorbs the drift that builds up over a long packet.

Writes are gated by packet framing. Outside a packet, line ones are ignored, and the first zero bit opens a packet. Inside a packet, a run of consecutive ones longer than any run that is legal in packet data marks the end of the packet. The reader then drains what is left, and both pointers return to empty for the next packet. A fill level output is provided. Overflow and underflow flags are sticky until the next packet starts.

Top module: `usb_rx_elastic`

## Requirements
- R1: After reset, fill_level is 0, out_valid is 0, and overflow and underflow are 0.
- R2: While no packet is open, valid 1 bits are not stored. The first valid 0 bit opens a packet and is stored as its first entry, so fill_level becomes 1.
- R3: A read slot produces no output until 8 entries have been written in the current packet. Once 8 entries are present, read slots produce output, and fill_level tracks the stored count.
- R4: Bits are delivered first-in first-out. out_valid and out_bit appear in the cycle after the accepted read slot, for that single cycle.
- R5: Inside a packet, the 7th consecutive valid 1 bit ends the packet and is not stored. The earlier six 1 bits are stored.
- R6: A valid 0 bit resets the consecutive-ones count. Six ones, a zero and six more ones keep the packet open, and all of these bits are stored.
- R7: After the packet ends, read slots drain the remaining entries in order. When the store becomes empty, it returns to the no-packet condition with fill_level 0.
- R8: A write attempt while 16 entries are held and no read is accepted in the same cycle is dropped, and overflow is set and stays set.
- R9: A read slot while the store is empty after prefill, with the packet still open, gives no output and sets underflow, which stays set.
- R10: Overflow and underflow are cleared by the bit that opens the next packet.
- R11: While a finished packet is draining, valid input bits of either value are not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Decoded line bit strobe from data recovery |
| in_bit | input | 1 | Decoded line bit value |
| rd_slot | input | 1 | Local bit-slot read request |
| out_valid | output | 1 | Output bit valid, one cycle after an accepted read slot |
| out_bit | output | 1 | Output bit |
| fill_level | output | 5 | Number of stored entries |
| overflow | output | 1 | Sticky write-while-full flag |
| underflow | output | 1 | Sticky read-while-empty flag |

## Verification
The hardest situations to reach from the ports are overflow and the boundary of the consecutive-ones count. Overflow needs 16 stored bits with no reads, and the bits must not contain any run that closes the packet. The bench therefore fills the store with runs of six ones split by single zeros, which also exercises the count reset. Underflow is reached by draining a streaming packet completely while it is still open. Both flags are then watched across the drain and the start of the next packet.

// File: rtl/usb_rx_elastic_pkg.sv
package usb_rx_elastic_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FILL   = 2'd1,
        ST_STREAM = 2'd2,
        ST_DRAIN  = 2'd3
    } rx_state_e;
endpackage

// File: rtl/usb_rx_ones_run.sv
module usb_rx_ones_run #(
    parameter int RUN_LIMIT = 7,
    localparam int CNTW = $clog2(RUN_LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic bit_valid,
    input  logic bit_in,
    output logic run_hit
);
    logic [CNTW-1:0] cnt_d, cnt_q;

    always_comb begin
        run_hit = enable && bit_valid && bit_in && (cnt_q == CNTW'(RUN_LIMIT - 1));
        cnt_d   = cnt_q;
        if (!enable) begin
            cnt_d = '0;
        end else if (bit_valid) begin
            if (!bit_in || run_hit) cnt_d = '0;
            else                    cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/usb_rx_bit_store.sv
module usb_rx_bit_store #(
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic          wdata,
    input  logic [AW-1:0] raddr,
    output logic          rdata
);
    logic [DEPTH-1:0] cells_q;

    always_ff @(posedge clk) begin
        if (we) cells_q[waddr] <= wdata;
    end

    assign rdata = cells_q[raddr];
endmodule

// File: rtl/usb_rx_elastic.sv
module usb_rx_elastic
    import usb_rx_elastic_pkg::*;
#(
    parameter int DEPTH     = 16,
    parameter int PREFILL   = 8,
    parameter int RUN_LIMIT = 7,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic          in_bit,
    input  logic          rd_slot,
    output logic          out_valid,
    output logic          out_bit,
    output logic [CW-1:0] fill_level,
    output logic          overflow,
    output logic          underflow
);
    typedef struct packed {
        rx_state_e   st;
        logic [AW-1:0] wptr;
        logic [AW-1:0] rptr;
        logic [CW-1:0] count;
        logic          ovf;
        logic          unf;
        logic          ovalid;
        logic          obit;
    } regs_t;

    regs_t r_d, r_q;

    logic in_pkt, run_hit, rdata;
    logic start, wr_try, wr_ok, pop;

    assign in_pkt = (r_q.st == ST_FILL) || (r_q.st == ST_STREAM);

    usb_rx_ones_run #(.RUN_LIMIT(RUN_LIMIT)) u_run (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (in_pkt),
        .bit_valid(in_valid),
        .bit_in   (in_bit),
        .run_hit  (run_hit)
    );

    usb_rx_bit_store #(.DEPTH(DEPTH)) u_store (
        .clk  (clk),
        .we   (wr_ok),
        .waddr(r_q.wptr),
        .wdata(in_bit),
        .raddr(r_q.rptr),
        .rdata(rdata)
    );

    always_comb begin
        r_d    = r_q;
        start  = (r_q.st == ST_IDLE) && in_valid && !in_bit;
        wr_try = start || (in_pkt && in_valid && !run_hit);
        pop    = rd_slot && ((r_q.st == ST_STREAM) || (r_q.st == ST_DRAIN))
                 && (r_q.count != '0);
        wr_ok  = wr_try && ((r_q.count != CW'(DEPTH)) || pop);

        if (wr_ok) r_d.wptr = r_q.wptr + 1'b1;
        if (pop)   r_d.rptr = r_q.rptr + 1'b1;
        r_d.count = r_q.count + CW'(wr_ok) - CW'(pop);

        r_d.ovalid = pop;
        r_d.obit   = pop ? rdata : 1'b0;

        if (start) begin
            r_d.ovf = 1'b0;
            r_d.unf = 1'b0;
        end else begin
            r_d.ovf = r_q.ovf || (wr_try && !wr_ok);
            r_d.unf = r_q.unf || (rd_slot && (r_q.st == ST_STREAM) && (r_q.count == '0));
        end

        unique case (r_q.st)
            ST_IDLE: begin
                if (start) r_d.st = ST_FILL;
            end
            ST_FILL: begin
                if (run_hit)                      r_d.st = ST_DRAIN;
                else if (r_d.count >= CW'(PREFILL)) r_d.st = ST_STREAM;
            end
            ST_STREAM: begin
                if (run_hit) r_d.st = ST_DRAIN;
            end
            ST_DRAIN: begin
                if (r_d.count == '0) begin
                    r_d.st   = ST_IDLE;
                    r_d.wptr = '0;
                    r_d.rptr = '0;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, wptr: '0, rptr: '0, count: '0,
                     ovf: 1'b0, unf: 1'b0, ovalid: 1'b0, obit: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign out_valid  = r_q.ovalid;
    assign out_bit    = r_q.obit;
    assign fill_level = r_q.count;
    assign overflow   = r_q.ovf;
    assign underflow  = r_q.unf;
endmodule

// File: rtl/usb_rx_elastic_chk.sv
module usb_rx_elastic_chk
    import usb_rx_elastic_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic          rd_slot,
    input logic          out_valid,
    input logic [CW-1:0] fill_level,
    input logic          overflow,
    input logic          underflow,
    input rx_state_e     st
);
    assert_fill_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fill_level <= CW'(DEPTH));

    assert_out_follows_slot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(rd_slot));

    assert_no_read_in_prefill_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_FILL) |=> !out_valid);

    assert_idle_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE) |-> (fill_level == '0));

    assert_ovf_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overflow) |-> ($past(in_valid) && ($past(fill_level) == CW'(DEPTH))));

    assert_unf_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(underflow) |-> ($past(rd_slot) && ($past(fill_level) == '0)));

    assert_drain_no_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_DRAIN) |=> (fill_level <= $past(fill_level)));
endmodule

bind usb_rx_elastic usb_rx_elastic_chk #(.DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .rd_slot   (rd_slot),
    .out_valid (out_valid),
    .fill_level(fill_level),
    .overflow  (overflow),
    .underflow (underflow),
    .st        (r_q.st)
);

// File: tb/usb_rx_elastic_bench.sv
module usb_rx_elastic_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic in_bit = 1'b0;
    logic rd_slot = 1'b0;
    logic out_valid, out_bit, overflow, underflow;
    logic [4:0] fill_level;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    usb_rx_elastic u_usb_rx_elastic (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_bit(in_bit),
        .rd_slot(rd_slot), .out_valid(out_valid), .out_bit(out_bit),
        .fill_level(fill_level), .overflow(overflow), .underflow(underflow)
    );

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic send(bit b);
        @(negedge clk);
        in_valid = 1'b1;
        in_bit   = b;
        @(negedge clk);
        in_valid = 1'b0;
        in_bit   = 1'b0;
    endtask

    // read slot; results are valid at the negedge after the accepting edge
    task automatic slot(output bit v, output bit b);
        @(negedge clk);
        rd_slot = 1'b1;
        @(negedge clk);
        rd_slot = 1'b0;
        v = out_valid;
        b = out_bit;
    endtask

    task automatic t_reset();
        check("R1 fill", fill_level, 0);
        check("R1 out_valid", out_valid, 0);
        check("R1 overflow", overflow, 0);
        check("R1 underflow", underflow, 0);
    endtask

    task automatic t_packet_one();
        bit v, b;
        bit pat[8] = '{0, 1, 0, 0, 1, 1, 0, 1};
        send(1); send(1);
        check("R2 ones ignored when idle", fill_level, 0);
        send(0);
        check("R2 start stored", fill_level, 1);
        slot(v, b);
        check("R3 no read at fill 1", v, 0);
        for (int i = 1; i < 7; i++) send(pat[i]);
        check("R3 fill 7", fill_level, 7);
        slot(v, b);
        check("R3 no read at fill 7", v, 0);
        send(pat[7]);
        check("R3 fill 8", fill_level, 8);
        for (int i = 0; i < 8; i++) begin
            slot(v, b);
            check("R4 valid", v, 1);
            check("R4 order", b, pat[i]);
        end
        check("R3 fill after reads", fill_level, 0);
        slot(v, b);
        check("R9 no output on empty", v, 0);
        check("R9 underflow set", underflow, 1);
        send(0);
        for (int i = 0; i < 6; i++) send(1);
        check("R5 six ones stored", fill_level, 7);
        send(1);
        check("R5 seventh one not stored", fill_level, 7);
        send(0);
        check("R11 drain ignores zero", fill_level, 7);
        send(1);
        check("R11 drain ignores one", fill_level, 7);
        for (int i = 0; i < 7; i++) begin
            slot(v, b);
            check("R7 drain valid", v, 1);
            check("R7 drain order", b, (i == 0) ? 0 : 1);
        end
        check("R7 empty after drain", fill_level, 0);
        check("R9 underflow sticky", underflow, 1);
        send(1);
        check("R7 idle ignores ones", fill_level, 0);
    endtask

    task automatic t_packet_two();
        bit v, b;
        send(0);
        check("R10 underflow cleared", underflow, 0);
        for (int i = 0; i < 6; i++) send(1);
        send(0);
        for (int i = 0; i < 6; i++) send(1);
        check("R6 runs split by zero stored", fill_level, 14);
        send(0);
        check("R6 packet still open", fill_level, 15);
        send(0);
        check("R8 full", fill_level, 16);
        check("R8 no overflow yet", overflow, 0);
        send(1);
        check("R8 dropped when full", fill_level, 16);
        check("R8 overflow set", overflow, 1);
        // close: run already has 1 one; six more give the seventh
        for (int i = 0; i < 6; i++) send(1);
        check("R8 overflow sticky", overflow, 1);
        for (int i = 0; i < 16; i++) begin
            slot(v, b);
            check("R7 drain valid", v, 1);
            if (i == 0 || i == 7 || i == 14 || i == 15) check("R4 order p2", b, 0);
            else                                         check("R4 order p2", b, 1);
        end
        check("R7 idle after drain", fill_level, 0);
        send(0);
        check("R10 overflow cleared", overflow, 0);
        check("R2 new start", fill_level, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_packet_one();
        t_packet_two();
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 20000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=0 expected=1");
        end
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule